// File: doc/BRIEF.md
# Two-Bank Data Memory Address Router

This block sits between a small processor core and its data storage. The core supplies a 7-bit direct address taken from the instruction and a bank-select bit taken from its status register. The router joins them into an 8-bit effective address, with the bank bit on top. It then sends each access to one of three places: the special-function register (SFR) space, an internal general-purpose RAM, or an empty region that reads as zero.

The two banks are not alike. Bank 0 has 96 bytes of private RAM above its SFR window. Bank 1 has only 32 private bytes. The top 16 bytes of bank 1 are a second view onto the top 16 bytes of bank 0, so the core can reach shared variables without switching banks. The rest of bank 1 does not exist. Physical storage is 128 bytes, and the shared window takes no extra storage.

RAM writes take effect on the rising clock edge while the write strobe is high. Reads are combinational from the current address and strobe. The SFR contents live outside this block. It only raises a select line toward them and passes their read data back.

Top module: `dmb_router`

## Requirements
- R1: The effective address is `{bank_sel, dir_addr}`, so bank_sel = 0 selects 00h-7Fh and bank_sel = 1 selects 80h-FFh.
- R2: For effective addresses 00h-1Fh and 80h-9Fh (dir_addr[6:5] = 00), `sfr_sel` is high whenever `rd_en` or `wr_en` is high. While `rd_en` is high, `rdata` equals `sfr_rdata`. An SFR write changes no RAM byte.
- R3: Effective addresses 20h-7Fh are RAM. A byte written with `wr_en` high at a rising edge is read back from that address afterwards.
- R4: Effective addresses A0h-BFh are RAM held apart from bank 0. Writing them changes no byte at 20h-7Fh.
- R5: Effective addresses F0h-FFh reach the same bytes as 70h-7Fh, for both reads and writes in either direction.
- R6: A read of effective address C0h-EFh returns 00h.
- R7: A write to C0h-EFh is discarded and leaves every RAM byte unchanged.
- R8: The two reserved bank bits `bank_rsvd` have no effect on any output or on storage.
- R9: A synchronous reset clears every RAM byte to 00h.
- R10: `rdata` is 00h while `rd_en` is low.
- R11: `sfr_sel` is low for every address outside the SFR windows, and low when neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bank_sel | input | 1 | Bank-select bit (0 = bank 0, 1 = bank 1) |
| bank_rsvd | input | 2 | Reserved bank bits, ignored |
| dir_addr | input | 7 | Direct address from the instruction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| sfr_sel | output | 1 | SFR access select |
| sfr_rdata | input | 8 | Read data returned by the SFR file |

## Verification
Each RAM region is filled with its own address-derived pattern, so reading back the other regions shows whether the bank bit and the offset arithmetic keep bank 0, private bank 1 RAM and the shared window apart. The shared window is written through one view and read through the other, in both directions, which tells a true alias from a separate copy. Writes of all-ones across the empty region, followed by a recheck of every RAM byte, tell a discarded write from a redirected one. SFR reads use a fixed marker on `sfr_rdata`, and the reserved bits are driven to 11 during ordinary accesses to show they change nothing.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    localparam int DATA_W   = 8;
    localparam int DADDR_W  = 7;
    localparam int EA_W     = DADDR_W + 1;
    localparam int SFR_SPAN = 32;
    localparam int B0_RAM   = 96;
    localparam int B1_RAM   = 32;
    localparam int RAM_D    = B0_RAM + B1_RAM;
    localparam int IDX_W    = $clog2(RAM_D);

    typedef enum logic [1:0] {
        RGN_SFR  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } dec_t;

    // Map an effective address onto a region and a physical RAM index.
    function automatic dec_t decode_ea(input logic [EA_W-1:0] ea);
        dec_t d;
        d.region = RGN_NONE;
        d.idx    = '0;
        if (ea[DADDR_W-1:DADDR_W-2] == 2'b00) begin
            d.region = RGN_SFR;
        end else if (!ea[EA_W-1]) begin
            d.region = RGN_RAM;
            d.idx    = IDX_W'(ea[DADDR_W-1:0] - DADDR_W'(SFR_SPAN));
        end else if (ea[DADDR_W-1:DADDR_W-2] == 2'b01) begin
            d.region = RGN_RAM;
            d.idx    = IDX_W'(B0_RAM) + IDX_W'(ea[4:0]);
        end else if (ea[DADDR_W-1:DADDR_W-3] == 3'b111) begin
            // shared window: same index as the bank 0 bytes below it
            d.region = RGN_RAM;
            d.idx    = IDX_W'(ea[DADDR_W-1:0] - DADDR_W'(SFR_SPAN));
        end
        return d;
    endfunction

endpackage

// File: rtl/dmb_decode.sv
module dmb_decode
    import dmb_pkg::*;
(
    input  logic               bank_sel,
    input  logic [DADDR_W-1:0] dir_addr,
    output logic [EA_W-1:0]    ea,
    output dec_t               dec
);
    always_comb begin
        ea  = {bank_sel, dir_addr};
        dec = decode_ea(ea);
    end
endmodule

// File: rtl/dmb_ram.sv
module dmb_ram
    import dmb_pkg::*;
#(
    parameter int DEPTH = RAM_D,
    parameter int DW    = DATA_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign q = mem[idx];

    // R3: a written byte holds the written value on the next cycle
    assert_ram_store_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(idx)] == $past(wdata));

    // R9: reset leaves the addressed byte at zero
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (rst || q == '0));
endmodule

// File: rtl/dmb_rmux.sv
module dmb_rmux
    import dmb_pkg::*;
(
    input  logic              rd_en,
    input  region_e           region,
    input  logic [DATA_W-1:0] ram_q,
    input  logic [DATA_W-1:0] sfr_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (region)
                RGN_SFR:  rdata = sfr_rdata;
                RGN_RAM:  rdata = ram_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmb_router.sv
module dmb_router
    import dmb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic               bank_sel,
    input  logic [1:0]         bank_rsvd,
    input  logic [DADDR_W-1:0] dir_addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               sfr_sel,
    input  logic [DATA_W-1:0]  sfr_rdata
);
    logic [EA_W-1:0]   ea;
    dec_t              dec;
    logic [DATA_W-1:0] ram_q;
    logic              ram_we;
    logic              rsvd_unused;

    assign rsvd_unused = ^bank_rsvd; // R8: reserved bits take no part in decoding

    dmb_decode u_dec (
        .bank_sel (bank_sel),
        .dir_addr (dir_addr),
        .ea       (ea),
        .dec      (dec)
    );

    assign ram_we  = wr_en && (dec.region == RGN_RAM);
    assign sfr_sel = (rd_en || wr_en) && (dec.region == RGN_SFR);

    dmb_ram #(.DEPTH(RAM_D), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .idx   (dec.idx),
        .wdata (wdata),
        .q     (ram_q)
    );

    dmb_rmux u_mux (
        .rd_en     (rd_en),
        .region    (dec.region),
        .ram_q     (ram_q),
        .sfr_rdata (sfr_rdata),
        .rdata     (rdata)
    );

    // R2: SFR window selects the SFR file on any strobe
    assert_sfr_select_R2: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && dir_addr[6:5] == 2'b00) |-> sfr_sel);

    // R2: SFR read data is passed straight through
    assert_sfr_data_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dir_addr[6:5] == 2'b00) |-> rdata == sfr_rdata);

    // R6: empty region reads as zero
    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bank_sel && dir_addr[6:5] != 2'b00 && dir_addr[6:5] != 2'b01
         && dir_addr[6:4] != 3'b111) |-> rdata == '0);

    // R10: no read strobe, no data
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);

    // R11: select stays low outside the SFR windows or without a strobe
    assert_no_sfr_R11: assert property (@(posedge clk) disable iff (rst)
        (dir_addr[6:5] != 2'b00 || !(rd_en || wr_en)) |-> !sfr_sel);

    // R7: no RAM write reaches storage from the empty region
    assert_empty_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_sel && dir_addr[6:5] == 2'b10) |-> !ram_we);

    // R1: effective address follows the bank bit
    assert_ea_bank_R1: assert property (@(posedge clk) disable iff (rst)
        ea[EA_W-1] == bank_sel && ea[DADDR_W-1:0] == dir_addr);
endmodule

// File: tb/dmb_router_test.sv
module dmb_router_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       rd_en = 0, wr_en = 0, bank_sel = 0;
    logic [1:0] bank_rsvd = 0;
    logic [6:0] dir_addr = 0;
    logic [7:0] wdata = 0, sfr_rdata = 0;
    logic [7:0] rdata;
    logic       sfr_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmb_router uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .bank_sel(bank_sel), .bank_rsvd(bank_rsvd), .dir_addr(dir_addr),
        .wdata(wdata), .rdata(rdata), .sfr_sel(sfr_sel), .sfr_rdata(sfr_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] ea, input logic [7:0] d);
        @(negedge clk);
        bank_sel = ea[7]; dir_addr = ea[6:0]; wdata = d; wr_en = 1; rd_en = 0;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] ea, output logic [7:0] d);
        @(negedge clk);
        bank_sel = ea[7]; dir_addr = ea[6:0]; rd_en = 1; wr_en = 0;
        #1 d = rdata;
        rd_en = 0;
    endtask

    function automatic logic [7:0] pat0(input int a); return 8'(a * 3 + 1); endfunction
    function automatic logic [7:0] pat1(input int a); return 8'(~(a * 5)); endfunction

    task automatic t_reset;
        logic [7:0] d;
        rd(8'h20, d); check("R9 reset 20h", d, 8'h00);
        rd(8'h7F, d); check("R9 reset 7Fh", d, 8'h00);
        rd(8'hBF, d); check("R9 reset BFh", d, 8'h00);
        @(negedge clk); dir_addr = 7'h20; bank_sel = 0; #1;
        check("R10 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_bank0;
        logic [7:0] d;
        for (int a = 'h20; a < 'h80; a++) wr(8'(a), pat0(a));
        for (int a = 'h20; a < 'h80; a++) begin
            rd(8'(a), d); check("R3 bank0 readback", d, pat0(a));
        end
        @(negedge clk); bank_sel = 0; dir_addr = 7'h31; #1;
        check("R10 no strobe over RAM", rdata, 8'h00);
    endtask

    task automatic t_bank1;
        logic [7:0] d;
        for (int a = 'hA0; a < 'hC0; a++) wr(8'(a), pat1(a));
        for (int a = 'hA0; a < 'hC0; a++) begin
            rd(8'(a), d); check("R4 bank1 readback", d, pat1(a));
        end
        for (int a = 'h20; a < 'h40; a++) begin
            rd(8'(a), d); check("R1 R4 bank0 untouched", d, pat0(a));
        end
    endtask

    task automatic t_alias;
        logic [7:0] d;
        for (int a = 'h70; a < 'h80; a++) begin
            rd(8'(a + 'h80), d); check("R5 F0 window sees bank0", d, pat0(a));
        end
        wr(8'hF5, 8'h5A); rd(8'h75, d); check("R5 write F5 read 75", d, 8'h5A);
        wr(8'h7A, 8'hC3); rd(8'hFA, d); check("R5 write 7A read FA", d, 8'hC3);
        rd(8'hB5, d); check("R5 bank1 private untouched", d, pat1('hB5));
        wr(8'h75, pat0('h75)); wr(8'h7A, pat0('h7A));
    endtask

    task automatic t_empty;
        logic [7:0] d;
        for (int a = 'hC0; a < 'hF0; a++) wr(8'(a), 8'hFF);
        for (int a = 'hC0; a < 'hF0; a++) begin
            rd(8'(a), d); check("R6 empty reads zero", d, 8'h00);
        end
        for (int a = 'h20; a < 'h80; a++) begin
            rd(8'(a), d); check("R7 bank0 unchanged", d, pat0(a));
        end
        for (int a = 'hA0; a < 'hC0; a++) begin
            rd(8'(a), d); check("R7 bank1 unchanged", d, pat1(a));
        end
    endtask

    task automatic t_sfr;
        logic [7:0] d;
        sfr_rdata = 8'h96;
        @(negedge clk); bank_sel = 0; dir_addr = 7'h05; rd_en = 1; #1;
        check("R2 sfr_sel bank0", {7'd0, sfr_sel}, 8'h01);
        check("R2 sfr data bank0", rdata, 8'h96);
        @(negedge clk); bank_sel = 1; dir_addr = 7'h1F; #1;
        check("R2 sfr_sel bank1", {7'd0, sfr_sel}, 8'h01);
        check("R2 sfr data bank1", rdata, 8'h96);
        @(negedge clk); rd_en = 0; wr_en = 1; bank_sel = 1; dir_addr = 7'h00; wdata = 8'h11; #1;
        check("R2 sfr_sel on write", {7'd0, sfr_sel}, 8'h01);
        @(negedge clk); wr_en = 0; dir_addr = 7'h05; #1;
        check("R11 no strobe no select", {7'd0, sfr_sel}, 8'h00);
        @(negedge clk); rd_en = 1; bank_sel = 0; dir_addr = 7'h20; #1;
        check("R11 RAM read no select", {7'd0, sfr_sel}, 8'h00);
        rd_en = 0;
        rd(8'h20, d); check("R2 SFR write left RAM", d, pat0('h20));
        rd(8'hA0, d); check("R2 SFR write left bank1", d, pat1('hA0));
    endtask

    task automatic t_rsvd;
        logic [7:0] d;
        bank_rsvd = 2'b11;
        wr(8'h30, 8'hE7); rd(8'h30, d); check("R8 rsvd bank0", d, 8'hE7);
        rd(8'hA1, d); check("R8 rsvd bank1", d, pat1('hA1));
        rd(8'hC8, d); check("R8 rsvd empty", d, 8'h00);
        bank_rsvd = 2'b00;
        rd(8'h30, d); check("R8 rsvd cleared", d, 8'hE7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_bank0;
        t_bank1;
        t_alias;
        t_empty;
        t_sfr;
        t_rsvd;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule